// File: doc/BRIEF.md
# Address-Pattern Partition Write Protector

This block sits between a host and a battery-backed static RAM and guards the RAM's write strobe. The memory is split into sixteen equal partitions, selected by the four highest address lines; the partition size is therefore the memory size divided by sixteen. A sixteen-bit protection map decides which partitions refuse writes. When the host pulls the write enable low and the upper address points at a protected partition, the gated write enable stays high and the RAM never sees the write.

The protection map is loaded without any data bus. The host issues twenty read cycles whose upper address nibbles follow a fixed unlock key. The next four reads then carry the map, four bits per read, on the same address lines. Any write cycle aborts the key, and so does a wrong nibble. Memory data returned by these reads has no meaning and is ignored.

A mode input enables the whole function. While it is low, the block leaves the strobe and the key logic idle and withdraws the output enable of its write-enable and power-fail pins. The mode is captured when the supply drops out of tolerance and is held through the outage. During the outage, writes are blocked, except that a write already in progress at the moment of failure may finish: either the host raises its write enable, or a bounded hold time runs out.

Top module: `partition_write_guard`

## Requirements
- R1: After the 20-read key, four reads load the map. The key's upper-address nibbles, bit 3 being the highest line, are F,E,7,7,3,9,C,E,7,3,9,4,2,4,A,6,9,1,0,5. In payload read k (0..3), line j (0..3) sets map bit 4k+j.
- R2: A write cycle, meaning WE was low while CE was low, returns the key matcher to its start. The key must then be sent again in full before any payload read is accepted.
- R3: A read whose nibble differs from the expected key nibble restarts the matcher. If that nibble equals the first key nibble (F), it counts as key step 1.
- R4: While power is good and mode is high, we_no equals we_ni for partitions whose map bit is 0. It is held at 1 when the map bit at index addr_hi_i is 1. The output reacts to its inputs with no clock latency.
- R5: Reset loads the map with the SEED_MAP parameter and leaves the matcher idle.
- R6: With power good and mode_i low, out_en_o is 0 and we_no is 1. Cycles, including a complete key and payload, leave the map unchanged.
- R7: While power is bad, we_no is 1. The exception is a write whose WE was already low when power failed: it passes until WE rises or HOLD_CYC clock edges after the first edge that sees the failure.
- R8: mode_i is captured when power_good falls. While power stays bad, out_en_o shows the captured value and ignores mode_i.
- R9: The map keeps its contents across a power failure.
- R10: A power failure abandons a partly received key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Host chip enable, active low |
| we_ni | input | 1 | Host write enable, active low |
| addr_hi_i | input | 4 | Four highest RAM address lines |
| mode_i | input | 1 | Function enable, captured at power failure |
| pwr_good_i | input | 1 | Supply within tolerance |
| we_no | output | 1 | Gated write enable to RAM, active low |
| out_en_o | output | 1 | Output enable for the write-enable and power-fail pins |

## Verification
Gating of we_no is combinational, so each probe drives a write at a falling clock edge and samples one nanosecond later, before any rising edge. Matcher steps and map loads take effect at the rising edge that sees CE high after a low phase. Every read and write task therefore ends one full period after raising CE, so the next probe already sees the updated map. For the power-fail hold, the bench counts rising edges from the first one that sees power_good low: it expects we_no still low after HOLD_CYC edges and high after HOLD_CYC+1.

// File: rtl/pwg_pkg.sv
`timescale 1ns/1ps
package pwg_pkg;
  localparam int unsigned LINES    = 4;
  localparam int unsigned PARTS    = 1 << LINES;
  localparam int unsigned KEY_LEN  = 20;
  localparam int unsigned LOAD_LEN = PARTS / LINES;
  localparam int unsigned SEQ_LEN  = KEY_LEN + LOAD_LEN;
  localparam int unsigned STEP_W   = $clog2(SEQ_LEN + 1);

  typedef logic [LINES-1:0]  nib_t;
  typedef logic [STEP_W-1:0] step_t;
  typedef logic [PARTS-1:0]  map_t;

  // key per address line, leftmost = first read
  localparam logic [0:KEY_LEN-1] KEY_L0 = 20'b10111100111000001101;
  localparam logic [0:KEY_LEN-1] KEY_L1 = 20'b11111001110010110000;
  localparam logic [0:KEY_LEN-1] KEY_L2 = 20'b11110011100101010001;
  localparam logic [0:KEY_LEN-1] KEY_L3 = 20'b11000111001000101000;

  typedef struct packed {
    logic done;
    logic wr;
    nib_t addr;
  } cyc_t;

  function automatic nib_t key_nib(input step_t s);
    return {KEY_L3[s], KEY_L2[s], KEY_L1[s], KEY_L0[s]};
  endfunction
endpackage

// File: rtl/pwg_cycle_mon.sv
`timescale 1ns/1ps
module pwg_cycle_mon
  import pwg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  nib_t addr_i,
  output cyc_t cyc_o
);
  logic ce_q;
  logic wr_seen_q;
  logic done;

  assign done = ~ce_q & ce_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q      <= 1'b1;
      wr_seen_q <= 1'b0;
    end else begin
      ce_q      <= ce_ni;
      wr_seen_q <= done ? 1'b0 : (wr_seen_q | (~ce_ni & ~we_ni));
    end
  end

  always_comb begin
    cyc_o.done = done;
    cyc_o.wr   = wr_seen_q | ~we_ni;
    cyc_o.addr = addr_i;
  end
endmodule

// File: rtl/pwg_unlock.sv
`timescale 1ns/1ps
module pwg_unlock
  import pwg_pkg::*;
#(
  parameter map_t SEED_MAP = 16'hA5C3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  cyc_t  cyc_i,
  output map_t  map_o,
  output step_t step_o
);
  localparam step_t KEY_END = step_t'(KEY_LEN);
  localparam step_t SEQ_END = step_t'(SEQ_LEN - 1);

  step_t step_q;
  map_t  map_q;
  step_t slot;

  assign slot = step_q - KEY_END;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      map_q  <= SEED_MAP;
    end else if (!en_i) begin
      step_q <= '0;
    end else if (cyc_i.done) begin
      if (cyc_i.wr) begin
        step_q <= '0;
      end else if (step_q < KEY_END) begin
        if (cyc_i.addr == key_nib(step_q))        step_q <= step_q + step_t'(1);
        else if (cyc_i.addr == key_nib(step_t'(0))) step_q <= step_t'(1);
        else                                       step_q <= '0;
      end else begin
        for (int unsigned k = 0; k < LOAD_LEN; k++) begin
          if (slot == step_t'(k)) map_q[k*LINES +: LINES] <= cyc_i.addr;
        end
        step_q <= (step_q == SEQ_END) ? '0 : step_q + step_t'(1);
      end
    end
  end

  assign map_o  = map_q;
  assign step_o = step_q;
endmodule

// File: rtl/pwg_pf_guard.sv
`timescale 1ns/1ps
module pwg_pf_guard #(
  parameter int unsigned HOLD_CYC = 300_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic mode_i,
  input  logic we_ni,
  output logic mode_eff_o,
  output logic pass_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  logic pg_q, mode_q, hold_q, hold_d, fall;
  logic [CNT_W-1:0] cnt_q;

  assign fall   = pg_q & ~pwr_good_i;
  assign hold_d = ~pwr_good_i & ~we_ni & (fall | (hold_q & (cnt_q < LAST)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_q   <= 1'b0;
      mode_q <= 1'b0;
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pg_q   <= pwr_good_i;
      if (fall) mode_q <= mode_i;
      hold_q <= hold_d;
      cnt_q  <= (hold_q & hold_d) ? cnt_q + CNT_W'(1) : '0;
    end
  end

  // mode follows the pin until the failure has been registered
  assign mode_eff_o = (pwr_good_i | pg_q) ? mode_i : mode_q;
  assign pass_o     = pwr_good_i | (~we_ni & (fall | hold_q));
endmodule

// File: rtl/partition_write_guard.sv
`timescale 1ns/1ps
module partition_write_guard
  import pwg_pkg::*;
#(
  parameter map_t        SEED_MAP = 16'hA5C3,
  parameter int unsigned HOLD_CYC = 300_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             we_ni,
  input  logic [LINES-1:0] addr_hi_i,
  input  logic             mode_i,
  input  logic             pwr_good_i,
  output logic             we_no,
  output logic             out_en_o
);
  cyc_t  cyc;
  map_t  prot_map;
  step_t step_cnt;
  logic  mode_eff, pf_pass, hit;

  pwg_cycle_mon u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_ni  (ce_ni),
    .we_ni  (we_ni),
    .addr_i (addr_hi_i),
    .cyc_o  (cyc)
  );

  pwg_unlock #(.SEED_MAP(SEED_MAP)) u_unlock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pwr_good_i & mode_i),
    .cyc_i  (cyc),
    .map_o  (prot_map),
    .step_o (step_cnt)
  );

  pwg_pf_guard #(.HOLD_CYC(HOLD_CYC)) u_pf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_good_i (pwr_good_i),
    .mode_i     (mode_i),
    .we_ni      (we_ni),
    .mode_eff_o (mode_eff),
    .pass_o     (pf_pass)
  );

  assign hit      = prot_map[addr_hi_i];
  assign we_no    = we_ni | ~mode_eff | ~pf_pass | hit;
  assign out_en_o = mode_eff;
endmodule

// File: rtl/pwg_checker.sv
`timescale 1ns/1ps
module pwg_checker
  import pwg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_ni,
  input logic             we_ni,
  input logic [LINES-1:0] addr_hi_i,
  input logic             mode_i,
  input logic             pwr_good_i,
  input logic             we_no,
  input logic             out_en_o,
  input map_t             prot_map,
  input step_t            step_cnt
);
  assert_unprot_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && mode_i && !prot_map[addr_hi_i]) |-> (we_no == we_ni));

  assert_prot_block_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && mode_i && prot_map[addr_hi_i]) |-> we_no);

  assert_mode_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && !mode_i) |-> (!out_en_o && we_no));

  assert_write_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && mode_i && ce_ni && $past(!ce_ni && !we_ni)) |=> (step_cnt == '0));

  assert_map_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> $stable(prot_map));

  assert_key_dropped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (step_cnt == '0));

  assert_mode_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_good_i && !$past(pwr_good_i) && !$past(pwr_good_i, 2)) |-> $stable(out_en_o));
endmodule

bind partition_write_guard pwg_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .we_ni      (we_ni),
  .addr_hi_i  (addr_hi_i),
  .mode_i     (mode_i),
  .pwr_good_i (pwr_good_i),
  .we_no      (we_no),
  .out_en_o   (out_en_o),
  .prot_map   (prot_map),
  .step_cnt   (step_cnt)
);

// File: tb/partition_write_guard_tb.sv
`timescale 1ns/1ps
module partition_write_guard_tb;
  localparam int H = 16;
  localparam logic [15:0] SEED = 16'hA5C3;
  // {addr[3:0], expected we_no during a write}, checked against SEED
  localparam logic [4:0] VEC [8] = '{5'h01, 5'h04, 5'h06, 5'h0D, 5'h11, 5'h12, 5'h1B, 5'h1C};
  localparam logic [3:0] KEY [20] = '{4'hF, 4'hE, 4'h7, 4'h7, 4'h3, 4'h9, 4'hC, 4'hE, 4'h7, 4'h3,
                                      4'h9, 4'h4, 4'h2, 4'h4, 4'hA, 4'h6, 4'h9, 4'h1, 4'h0, 4'h5};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, mode = 1'b1, pg = 1'b1;
  logic [3:0] addr = '0;
  logic we_o, oe_o;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  partition_write_guard #(.SEED_MAP(SEED), .HOLD_CYC(H)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .addr_hi_i(addr),
    .mode_i(mode), .pwr_good_i(pg), .we_no(we_o), .out_en_o(oe_o)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic probe(input logic [3:0] a, input logic exp, input string req);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a;
    #1 chk(we_o, exp, req);
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prog(input logic [15:0] v);
    for (int i = 0; i < 20; i++) rd(KEY[i]);
    for (int k = 0; k < 4; k++) rd(v[4*k +: 4]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(oe_o, 1'b1, "R5 out_en after reset");
    chk(we_o, 1'b1, "R5 we_no idle after reset");

    // R4/R5: seed map gating, table driven
    for (int i = 0; i < 8; i++) probe(VEC[i][4:1], VEC[i][0], "R4 seed gating");

    // R1: load 0x1234 and probe every partition
    prog(16'h1234);
    for (int p = 0; p < 16; p++) begin
      logic [15:0] m = 16'h1234;
      probe(4'(p), m[p], "R1 map load");
    end

    // R2: write inside the key aborts it
    for (int i = 0; i < 10; i++) rd(KEY[i]);
    probe(4'h0, 1'b0, "R2 write passes mid key");
    for (int i = 10; i < 20; i++) rd(KEY[i]);
    for (int k = 0; k < 4; k++) rd(4'hF);
    probe(4'h0, 1'b0, "R2 aborted key left map");
    probe(4'h2, 1'b1, "R2 aborted key left map");

    // R3: junk, partial key, mismatch equal to first nibble, rest of key
    rd(4'h3); rd(KEY[0]); rd(KEY[1]); rd(KEY[2]); rd(4'hF);
    for (int i = 1; i < 20; i++) rd(KEY[i]);
    for (int k = 0; k < 4; k++) rd(4'h0);
    probe(4'h2, 1'b0, "R3 restart accepted");
    probe(4'hC, 1'b0, "R3 restart accepted");

    // R6: mode low
    @(negedge clk); mode = 1'b0;
    #1 chk(oe_o, 1'b0, "R6 out_en low");
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = 4'h1;
    #1 chk(we_o, 1'b1, "R6 we_no held high");
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    prog(16'hFFFF);
    @(negedge clk); mode = 1'b1;
    probe(4'h0, 1'b0, "R6 key ignored");
    probe(4'h7, 1'b0, "R6 key ignored");

    // R7/R8: power fail during a write
    prog(16'h0001);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = 4'h3;
    #1 chk(we_o, 1'b0, "R7 write before fail");
    @(negedge clk); pg = 1'b0;
    #1 chk(we_o, 1'b0, "R7 grace at fail");
    chk(oe_o, 1'b1, "R8 captured mode");
    repeat (H) @(posedge clk);
    @(negedge clk); chk(we_o, 1'b0, "R7 hold before limit");
    @(posedge clk);
    @(negedge clk); chk(we_o, 1'b1, "R7 hold expired");
    mode = 1'b0;
    #1 chk(oe_o, 1'b1, "R8 mode pin ignored");
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = 4'h3;
    #1 chk(we_o, 1'b1, "R7 new write blocked");
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    // write held low then released early
    @(negedge clk); pg = 1'b1; mode = 1'b1;
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = 4'h3;
    @(negedge clk); pg = 1'b0;
    repeat (3) @(negedge clk);
    chk(we_o, 1'b0, "R7 hold within limit");
    we_n = 1'b1;
    #1 chk(we_o, 1'b1, "R7 WE release");
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); pg = 1'b1;
    @(negedge clk);

    // R9: map survived
    probe(4'h0, 1'b1, "R9 map kept");
    probe(4'h1, 1'b0, "R9 map kept");

    // R10: outage abandons partial key
    for (int i = 0; i < 10; i++) rd(KEY[i]);
    @(negedge clk); pg = 1'b0;
    repeat (2) @(negedge clk);
    pg = 1'b1;
    @(negedge clk);
    for (int i = 10; i < 20; i++) rd(KEY[i]);
    for (int k = 0; k < 4; k++) rd(4'h0);
    probe(4'h0, 1'b1, "R10 key abandoned");

    done = 1;
    summary();
    $finish;
  end
endmodule